// File: doc/BRIEF.md
# Serial Register-Access Slave

This block lets a host microcontroller reach a 64-entry, byte-wide register file over a four-wire serial link. The link has an active-low chip select, a serial clock, a data input and a data output. The host lowers chip select and exchanges whole bytes, most significant bit first. The first byte of each sequence carries a command and a register address. What follows depends on the command: a pipelined read, a single write, a burst of writes to one address, or a sync byte that does nothing.

The three serial inputs pass through two-flop synchronizers into the system clock domain, and edge detection happens there. The block drives a simple parallel port into the register file: an address, write data and a write strobe, plus a read strobe with a clear qualifier and combinational read data. The output byte always runs one byte behind. The value fetched by a read, or the value read back after a write, is shifted out during the next byte. That value is also kept across chip-select cycles.

Top module: `mw_reg_slave`

## Requirements
- R1: After reset, `sdo` is 0 and none of `rf_wr`, `rf_rd` or `rf_clr` is asserted.
- R2: Bits move most significant first. `sdi` is sampled on each rising serial clock edge. `sdo` changes only after falling edges. Each byte is eight serial clocks, and a byte completes after the eighth falling edge.
- R3: The first byte after chip select falls is a command byte. Bits 7:6 hold the command (00 read, 01 write, 10 burst write, 11 sync) and bits 5:0 hold the address. A read command makes the next byte shift out that register's contents.
- R4: The first byte after chip select falls shifts out the most recently held output value. That value survives chip select going high.
- R5: A write command is followed by exactly one data byte, which is written to the address. The byte after that shifts out the value read back after the write. The next byte is then a command again.
- R6: A burst command makes every following byte a data byte for the same address, until chip select rises. Each data byte shifts out the read-back of the previous write.
- R7: A sync command touches no register and leaves the held output value unchanged.
- R8: `rf_clr` is asserted only together with `rf_rd`, and only for a read command. It is never asserted for read-backs after writes or for sync.
- R9: For an address whose bit is set in `TXD_MASK`, a write is not read back. The next byte shifts out zero.
- R10: Chip select rising discards any partial byte and ends burst mode. The next sequence starts with a command byte.
- R11: A write strobe is followed in the next system cycle by its read-back strobe on the same address. The write and read strobes never overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial clock half-period must span at least 8 of its cycles |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| rf_addr | output | AW | Register file address |
| rf_wdata | output | AW+2 | Register file write data |
| rf_wr | output | 1 | Register file write strobe |
| rf_rd | output | 1 | Register file read strobe |
| rf_clr | output | 1 | Clear qualifier for clear-on-read bits, valid with rf_rd |
| rf_rdata | input | AW+2 | Register file read data, combinational on rf_addr |

## Verification
The bench uses the default 6-bit address and marks address 0x3E in `TXD_MASK`. This lets a write to a transmit-data location be checked for a zero read-back and a missing read strobe. Address 0x10 of the bench's register file model clears on a qualified read. That makes a read-back that wrongly carries the clear qualifier show up as a later read returning zero. The serial clock half-period is 8 system cycles, which covers the synchronizer and pipeline latency. This exercises back-to-back bytes, burst streams ended by chip select, and a chip-select abort in the middle of a byte.

// File: rtl/mw_pkg.sv
package mw_pkg;

    localparam int CMD_W = 2;

    typedef enum logic [CMD_W-1:0] {
        CMD_READ  = 2'b00,
        CMD_WRITE = 2'b01,
        CMD_BURST = 2'b10,
        CMD_SYNC  = 2'b11
    } mw_cmd_e;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_WDATA,
        PH_BURST
    } mw_phase_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_READ,
        OP_WRITE
    } mw_op_e;

    function automatic logic op_reads_back(input mw_op_e op, input logic is_txd);
        return (op == OP_READ) || ((op == OP_WRITE) && !is_txd);
    endfunction

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/mw_shifter.sv
module mw_shifter #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n_s,
    input  logic          sck_s,
    input  logic          sdi_s,
    input  logic          load,
    input  logic [BW-1:0] load_val,
    input  logic [BW-1:0] hold_val,
    output logic          byte_done,
    output logic [BW-1:0] rx_byte,
    output logic          cs_rise,
    output logic          sdo
);
    localparam int CW = $clog2(BW + 1);

    logic          cs_q, sck_q;
    logic [BW-1:0] rx_q, tx_q;
    logic [CW-1:0] cnt_q;
    logic          cs_fall, sck_rise, sck_fall;

    assign cs_fall  = cs_q & ~cs_n_s;
    assign cs_rise  = ~cs_q & cs_n_s;
    assign sck_rise = ~sck_q & sck_s & ~cs_n_s;
    assign sck_fall = sck_q & ~sck_s & ~cs_n_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q      <= 1'b1;
            sck_q     <= 1'b0;
            rx_q      <= '0;
            tx_q      <= '0;
            cnt_q     <= '0;
            byte_done <= 1'b0;
        end else begin
            cs_q      <= cs_n_s;
            sck_q     <= sck_s;
            byte_done <= 1'b0;
            if (cs_n_s) begin
                cnt_q <= '0;
            end else if (sck_rise) begin
                rx_q  <= {rx_q[BW-2:0], sdi_s};
                cnt_q <= cnt_q + 1'b1;
            end else if (sck_fall) begin
                if (cnt_q == CW'(BW)) begin
                    byte_done <= 1'b1;
                    cnt_q     <= '0;
                end else begin
                    tx_q <= {tx_q[BW-2:0], 1'b0};
                end
            end
            if (cs_fall) begin
                tx_q <= hold_val;
            end else if (load) begin
                tx_q <= load_val;
            end
        end
    end

    assign rx_byte = rx_q;
    assign sdo     = tx_q[BW-1];
endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
    import mw_pkg::*;
#(
    parameter int              AW       = 6,
    parameter logic [2**AW-1:0] TXD_MASK = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            byte_done,
    input  logic [AW+1:0]   rx_byte,
    input  logic            cs_rise,
    input  logic [AW+1:0]   rf_rdata,
    output logic [AW-1:0]   rf_addr,
    output logic [AW+1:0]   rf_wdata,
    output logic            rf_wr,
    output logic            rf_rd,
    output logic            rf_clr,
    output logic            load,
    output logic [AW+1:0]   load_val,
    output logic [AW+1:0]   hold_val
);
    localparam int BW = AW + 2;

    mw_phase_e     phase_q;
    mw_op_e        s1_op_q;
    logic          s1_v_q, s2_v_q, s2_rd_q, s2_clr_q, s2_zero_q;
    logic [AW-1:0] addr_q;
    logic [BW-1:0] wdata_q, hold_q;
    mw_cmd_e       cmd;

    assign cmd = mw_cmd_e'(rx_byte[BW-1:AW]);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_CMD;
            s1_op_q   <= OP_NONE;
            s1_v_q    <= 1'b0;
            s2_v_q    <= 1'b0;
            s2_rd_q   <= 1'b0;
            s2_clr_q  <= 1'b0;
            s2_zero_q <= 1'b0;
            addr_q    <= '0;
            wdata_q   <= '0;
            hold_q    <= '0;
        end else begin
            s1_v_q <= byte_done;
            if (byte_done) begin
                unique case (phase_q)
                    PH_CMD: begin
                        addr_q  <= rx_byte[AW-1:0];
                        s1_op_q <= (cmd == CMD_READ) ? OP_READ : OP_NONE;
                        if (cmd == CMD_WRITE)      phase_q <= PH_WDATA;
                        else if (cmd == CMD_BURST) phase_q <= PH_BURST;
                    end
                    PH_WDATA: begin
                        s1_op_q <= OP_WRITE;
                        wdata_q <= rx_byte;
                        phase_q <= PH_CMD;
                    end
                    default: begin
                        s1_op_q <= OP_WRITE;
                        wdata_q <= rx_byte;
                    end
                endcase
            end
            if (cs_rise) phase_q <= PH_CMD;

            s2_v_q    <= s1_v_q;
            s2_rd_q   <= s1_v_q && op_reads_back(s1_op_q, TXD_MASK[addr_q]);
            s2_clr_q  <= s1_op_q == OP_READ;
            s2_zero_q <= (s1_op_q == OP_WRITE) && TXD_MASK[addr_q];
            if (s2_v_q) hold_q <= load_val;
        end
    end

    assign rf_addr  = addr_q;
    assign rf_wdata = wdata_q;
    assign rf_wr    = s1_v_q && (s1_op_q == OP_WRITE);
    assign rf_rd    = s2_v_q && s2_rd_q;
    assign rf_clr   = rf_rd && s2_clr_q;
    assign load     = s2_v_q;
    assign load_val = s2_rd_q ? rf_rdata : (s2_zero_q ? '0 : hold_q);
    assign hold_val = hold_q;
endmodule

// File: rtl/mw_reg_slave.sv
module mw_reg_slave #(
    parameter int               AW       = 6,
    parameter logic [2**AW-1:0] TXD_MASK = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          sck,
    input  logic          sdi,
    output logic          sdo,
    output logic [AW-1:0] rf_addr,
    output logic [AW+1:0] rf_wdata,
    output logic          rf_wr,
    output logic          rf_rd,
    output logic          rf_clr,
    input  logic [AW+1:0] rf_rdata
);
    localparam int BW = AW + 2;

    logic [2:0]    pins_s;
    logic          byte_done, cs_rise, load;
    logic [BW-1:0] rx_byte, load_val, hold_val;

    mw_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n, sck, sdi}),
        .q   (pins_s)
    );

    mw_shifter #(.BW(BW)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .cs_n_s    (pins_s[2]),
        .sck_s     (pins_s[1]),
        .sdi_s     (pins_s[0]),
        .load      (load),
        .load_val  (load_val),
        .hold_val  (hold_val),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .cs_rise   (cs_rise),
        .sdo       (sdo)
    );

    mw_ctrl #(.AW(AW), .TXD_MASK(TXD_MASK)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .cs_rise   (cs_rise),
        .rf_rdata  (rf_rdata),
        .rf_addr   (rf_addr),
        .rf_wdata  (rf_wdata),
        .rf_wr     (rf_wr),
        .rf_rd     (rf_rd),
        .rf_clr    (rf_clr),
        .load      (load),
        .load_val  (load_val),
        .hold_val  (hold_val)
    );
endmodule

// File: rtl/mw_reg_slave_chk.sv
module mw_reg_slave_chk #(
    parameter int               AW       = 6,
    parameter logic [2**AW-1:0] TXD_MASK = '0
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] rf_addr,
    input logic          rf_wr,
    input logic          rf_rd,
    input logic          rf_clr
);
    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rf_wr, rf_rd}));

    // R5
    wr_readback_chk: assert property (@(posedge clk) disable iff (rst)
        (rf_wr && !TXD_MASK[rf_addr]) |=> (rf_rd && !rf_clr));

    // R9
    txd_no_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rf_wr && TXD_MASK[rf_addr]) |=> !rf_rd);

    // R8
    clr_with_rd_chk: assert property (@(posedge clk) disable iff (rst)
        rf_clr |-> rf_rd);

    // R11
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rf_wr |=> $stable(rf_addr));
endmodule

bind mw_reg_slave mw_reg_slave_chk #(.AW(AW), .TXD_MASK(TXD_MASK)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rf_addr (rf_addr),
    .rf_wr   (rf_wr),
    .rf_rd   (rf_rd),
    .rf_clr  (rf_clr)
);

// File: tb/tb_mw_reg_slave.sv
module tb_mw_reg_slave;
    localparam int         CLK_PERIOD = 10;
    localparam int         HALF       = 8;
    localparam int         AW         = 6;
    localparam int         DEPTH      = 2**AW;
    localparam logic [5:0] COR_ADDR   = 6'h10;
    localparam logic [5:0] TXD_ADDR   = 6'h3E;
    localparam logic [DEPTH-1:0] TXD_MASK = DEPTH'(1) << TXD_ADDR;

    logic       clk = 1'b0, rst = 1'b1;
    logic       cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
    logic       sdo, rf_wr, rf_rd, rf_clr;
    logic [5:0] rf_addr;
    logic [7:0] rf_wdata, rf_rdata;

    mw_reg_slave #(.AW(AW), .TXD_MASK(TXD_MASK)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi), .sdo(sdo),
        .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_wr(rf_wr), .rf_rd(rf_rd),
        .rf_clr(rf_clr), .rf_rdata(rf_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // register file storage model; address COR_ADDR clears on a qualified read
    logic [7:0] store [DEPTH];
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) store[i] <= 8'(i) ^ 8'hA5;
        end else if (rf_wr) begin
            store[rf_addr] <= rf_wdata;
        end else if (rf_rd && rf_clr && rf_addr == COR_ADDR) begin
            store[rf_addr] <= 8'h00;
        end
    end
    assign rf_rdata = store[rf_addr];

    int checks = 0, errors = 0, clr_seen = 0, clr_exp = 0;
    always @(posedge clk) if (!rst && rf_clr) clr_seen++;

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    typedef struct { logic [7:0] v; bit care; string tag; } exp_t;
    exp_t exq[$];

    // monitor: host samples sdo at each rising serial clock
    int         mon_n = 0;
    logic [7:0] mon_b = 8'h00;
    always @(posedge sck or posedge cs_n) begin
        if (cs_n) begin
            mon_n = 0;
        end else begin
            mon_b = {mon_b[6:0], sdo};
            mon_n++;
            if (mon_n == 8) begin
                exp_t e;
                mon_n = 0;
                if (exq.size() == 0) begin
                    chk(1'b0, "R2 unexpected byte", mon_b, 8'h00);
                end else begin
                    e = exq.pop_front();
                    if (e.care) chk(mon_b == e.v, e.tag, mon_b, e.v);
                end
            end
        end
    end

    // predictor state
    logic [7:0] ref_mem [DEPTH];
    logic [7:0] nxt = 8'h00;
    bit         nxt_care = 1'b1;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbyte(input logic [7:0] din, input string tag);
        exq.push_back('{v: nxt, care: nxt_care, tag: tag});
        for (int i = 7; i >= 0; i--) begin
            sdi = din[i];
            wait_clk(HALF);
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic cs_begin();
        cs_n = 1'b0;
        wait_clk(2*HALF);
    endtask

    task automatic cs_end();
        wait_clk(2*HALF);
        cs_n = 1'b1;
        wait_clk(4*HALF);
    endtask

    task automatic do_read(input logic [5:0] a, input string tag);
        xbyte({2'b00, a}, tag);
        clr_exp++;
        nxt = ref_mem[a];
        nxt_care = 1'b1;
        if (a == COR_ADDR) ref_mem[a] = 8'h00;
    endtask

    task automatic do_sync(input string tag);
        xbyte(8'hC0, tag);
    endtask

    task automatic wr_data(input logic [5:0] a, input logic [7:0] d, input string tag);
        xbyte(d, tag);
        ref_mem[a] = d;
        nxt = (a == TXD_ADDR) ? 8'h00 : d;
        nxt_care = (a != TXD_ADDR);
    endtask

    task automatic do_write(input logic [5:0] a, input logic [7:0] d, input string tag);
        xbyte({2'b01, a}, tag);
        wr_data(a, d, tag);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'(i) ^ 8'hA5;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);
        // R1 reset state
        chk(sdo == 1'b0, "R1 sdo", 8'(sdo), 8'h00);
        chk({rf_wr, rf_rd, rf_clr} == 3'b000, "R1 strobes", 8'({rf_wr, rf_rd, rf_clr}), 8'h00);

        // R2 R3 R4: pipelined reads, first byte shows held value
        cs_begin();
        do_read(6'h05, "R4 first byte held");
        do_read(6'h3F, "R3 read 0x05 data");
        do_sync("R3 R2 read 0x3F data");
        do_sync("R7 sync keeps value");
        cs_end();

        // R5 single write then next command
        cs_begin();
        do_write(6'h07, 8'h3C, "R4 held across cs");
        do_sync("R5 write readback");
        do_read(6'h07, "R7 sync after write");
        do_sync("R5 stored value");
        cs_end();

        // R6 burst, R10 cs rise ends burst
        cs_begin();
        xbyte({2'b10, 6'h09}, "R6 burst cmd byte");
        wr_data(6'h09, 8'h11, "R6 burst first data");
        wr_data(6'h09, 8'h22, "R6 readback 11");
        wr_data(6'h09, 8'h33, "R6 readback 22");
        cs_end();
        cs_begin();
        do_read(6'h09, "R6 last readback held");
        do_sync("R10 new cmd after burst");
        cs_end();

        // R8 clear-on-read only for read commands
        cs_begin();
        do_write(COR_ADDR, 8'h77, "R8 pre");
        do_sync("R8 readback no clear");
        do_sync("R8 sync no clear");
        do_read(COR_ADDR, "R8 still held");
        do_read(COR_ADDR, "R8 read value 77");
        do_sync("R8 cleared by read");
        cs_end();

        // R9 transmit-data address read-back is zero
        cs_begin();
        do_write(TXD_ADDR, 8'h5A, "R9 pre");
        do_sync("R9 readback dont care");
        nxt_care = 1'b1;
        do_read(TXD_ADDR, "R9 held zero");
        do_sync("R9 stored value");
        cs_end();

        // R10 abort partial byte
        cs_n = 1'b0;
        wait_clk(2*HALF);
        for (int i = 0; i < 4; i++) begin
            sdi = 1'b1;
            wait_clk(HALF); sck = 1'b1;
            wait_clk(HALF); sck = 1'b0;
        end
        cs_end();
        cs_begin();
        do_read(6'h05, "R10 after abort held");
        do_sync("R10 aligned read");
        cs_end();

        wait_clk(4*HALF);
        chk(exq.size() == 0, "R2 all bytes seen", 8'(exq.size()), 8'h00);
        chk(clr_seen == clr_exp, "R8 clear count", 8'(clr_seen), 8'(clr_exp));
        chk(store[6'h07] == 8'h3C, "R5 storage", store[6'h07], 8'h3C);
        chk(store[6'h09] == 8'h33, "R6 storage", store[6'h09], 8'h33);
        chk(store[TXD_ADDR] == 8'h5A, "R9 storage", store[TXD_ADDR], 8'h5A);
        chk(!rf_wr && !rf_rd, "R11 idle strobes", 8'({rf_wr, rf_rd}), 8'h00);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule